// File: doc/BRIEF.md
# Core Voltage Rail Update Sequencer

This block turns a requested core supply voltage, given in millivolts, into target codes for three regulator rails (the CPU rail, the peripheral rail and the SoC rail). It places the codes in one packed control word, writing all three fields on the same clock edge. After the write it stays busy for a settling interval measured in ticks of an external microsecond strobe, so that a supply ramp can complete before anything relies on the new voltage. Each code counts 25 mV steps above a 700 mV base. The CPU and peripheral rails take the requested code. The SoC rail is held at or above a floor of 1150 mV. Only upward steps charge settle time, and the first update after reset always takes a long fixed settle.

A request is offered with `req_valid` and `req_mv` and is taken in a cycle where `req_ready` is high. The sequencer is an FSM with four states. ST_IDLE accepts a request and moves to ST_DECIDE (transition *accept*). ST_DECIDE compares the new code with the code currently applied. It goes straight to ST_FINISH when the code is unchanged (*skip*, nothing written) or when the write needs no wait (*write-no-wait*). Otherwise it writes the word, loads the settle timer and enters ST_SETTLE (*write-and-wait*). ST_SETTLE moves to ST_FINISH on the microsecond tick that uses up the timer (*expire*). ST_FINISH pulses `done` for one cycle and returns to ST_IDLE (*release*). A request outside the legal range is clamped, and the clamp raises a sticky error flag.

Top module: `vrail_seq`

## Requirements
- R1: Reset state: `req_ready`=1, `done`=0, `clamp_err`=0, `ctrl_word`=0.
- R2: The requested code is floor((mv-700)/25). It is written to the CPU field `ctrl_word[4:0]` and to the peripheral field `ctrl_word[9:5]`.
- R3: The SoC field `ctrl_word[14:10]` receives the larger of the requested code and 18.
- R4: A request below 950 mV is raised to code 10. A request whose code would exceed 31 is lowered to code 31. Either clamp sets `clamp_err`.
- R5: `clamp_err` stays set until reset, including through later in-range requests.
- R6: When a write raises the code above the applied code, `done` comes exactly 6 microsecond ticks per code step after the write.
- R7: When a write lowers the code, `done` comes without any tick being consumed.
- R8: When the requested code equals the applied code, `ctrl_word` is not changed and `done` comes without any tick.
- R9: The first update after reset always writes the word and waits exactly 168 ticks, whatever the requested code.
- R10: `req_ready` is low from the cycle after acceptance until `done`. It is high again in the cycle after the `done` pulse, and `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_mv | input | 12 | Requested voltage in millivolts |
| ctrl_word | output | 15 | Packed rail codes: CPU [4:0], peripheral [9:5], SoC [14:10] |
| done | output | 1 | One-cycle pulse when an update finishes |
| clamp_err | output | 1 | Sticky flag: a request was clamped |

## Verification
The assertions assume that `req_mv` is held stable while `req_valid` is high and that `us_tick` is a single-cycle pulse. They also assume that every written word was produced by the code converter, so a written CPU code is never below 10. The stimulus presents each request for exactly one cycle while `req_ready` is high and drives the tick only during the settle phase, one pulse per cycle. Random millivolt values from 600 to 1600 cover both clamps and every size of step, and directed values cover the floors, the ceiling, repeated and downward requests, and values between grid points.

// File: rtl/vrail_pkg.sv
package vrail_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SETTLE,
        ST_FINISH
    } vrail_state_e;

    localparam int RAIL_CPU    = 0;
    localparam int RAIL_PERIPH = 1;
    localparam int RAIL_SOC    = 2;
    localparam int NUM_RAILS   = 3;
endpackage

// File: rtl/vrail_code_conv.sv
module vrail_code_conv #(
    parameter int MV_W     = 12,
    parameter int CODE_W   = 5,
    parameter int BASE_MV  = 700,
    parameter int STEP_MV  = 25,
    parameter int MIN_CODE = 10,
    parameter int MAX_CODE = 31
) (
    input  logic [MV_W-1:0]   mv,
    output logic [CODE_W-1:0] code,
    output logic              clamped
);
    localparam int MIN_MV = BASE_MV + MIN_CODE * STEP_MV;

    logic [MV_W-1:0] raw;

    always_comb begin
        raw     = (mv - MV_W'(BASE_MV)) / MV_W'(STEP_MV);
        code    = CODE_W'(MIN_CODE);
        clamped = 1'b0;
        if (mv < MV_W'(MIN_MV)) begin
            code    = CODE_W'(MIN_CODE);
            clamped = 1'b1;
        end else if (raw > MV_W'(MAX_CODE)) begin
            code    = CODE_W'(MAX_CODE);
            clamped = 1'b1;
        end else begin
            code    = raw[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/vrail_word_pack.sv
module vrail_word_pack
    import vrail_pkg::*;
#(
    parameter int CODE_W    = 5,
    parameter int SOC_FLOOR = 18
) (
    input  logic [CODE_W-1:0]           code,
    output logic [NUM_RAILS*CODE_W-1:0] word
);
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        if (g == RAIL_SOC) begin : g_floor
            assign word[g*CODE_W +: CODE_W] =
                (code < CODE_W'(SOC_FLOOR)) ? CODE_W'(SOC_FLOOR) : code;
        end else begin : g_follow
            assign word[g*CODE_W +: CODE_W] = code;
        end
    end
endmodule

// File: rtl/vrail_settle_timer.sv
module vrail_settle_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              tick,
    output logic              fire
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fire = tick && (cnt_q == WAIT_W'(1));
endmodule

// File: rtl/vrail_seq.sv
module vrail_seq
    import vrail_pkg::*;
#(
    parameter int MV_W         = 12,
    parameter int CODE_W       = 5,
    parameter int BASE_MV      = 700,
    parameter int STEP_MV      = 25,
    parameter int CPU_MIN_CODE = 10,
    parameter int SOC_FLOOR    = 18,
    parameter int US_PER_STEP  = 6,
    parameter int INIT_STEPS   = 28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  us_tick,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [MV_W-1:0]       req_mv,
    output logic [3*CODE_W-1:0]   ctrl_word,
    output logic                  done,
    output logic                  clamp_err
);
    localparam int MAX_CODE  = (1 << CODE_W) - 1;
    localparam int WORD_W    = NUM_RAILS * CODE_W;
    localparam int MAX_STEPS = (INIT_STEPS > MAX_CODE) ? INIT_STEPS : MAX_CODE;
    localparam int MAX_WAIT  = MAX_STEPS * US_PER_STEP;
    localparam int WAIT_W    = $clog2(MAX_WAIT + 1);

    vrail_state_e state_q, state_d;

    logic [CODE_W-1:0] conv_code;
    logic              conv_clamped;
    logic [CODE_W-1:0] req_code_q;
    logic [CODE_W-1:0] cur_code_q;
    logic              init_done_q;
    logic [WORD_W-1:0] packed_word;
    logic [WORD_W-1:0] word_q;
    logic              err_q;
    logic              skip;
    logic [WAIT_W-1:0] wait_val;
    logic [WAIT_W-1:0] diff_ext;
    logic              timer_load;
    logic              timer_fire;
    logic              accept;

    vrail_code_conv #(
        .MV_W     (MV_W),
        .CODE_W   (CODE_W),
        .BASE_MV  (BASE_MV),
        .STEP_MV  (STEP_MV),
        .MIN_CODE (CPU_MIN_CODE),
        .MAX_CODE (MAX_CODE)
    ) u_conv (
        .mv      (req_mv),
        .code    (conv_code),
        .clamped (conv_clamped)
    );

    vrail_word_pack #(
        .CODE_W    (CODE_W),
        .SOC_FLOOR (SOC_FLOOR)
    ) u_pack (
        .code (req_code_q),
        .word (packed_word)
    );

    vrail_settle_timer #(
        .WAIT_W (WAIT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (wait_val),
        .tick     (us_tick),
        .fire     (timer_fire)
    );

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign skip       = init_done_q && (req_code_q == cur_code_q);
    assign timer_load = (state_q == ST_DECIDE) && !skip;

    always_comb begin
        diff_ext = WAIT_W'(req_code_q - cur_code_q);
        if (!init_done_q) begin
            wait_val = WAIT_W'(INIT_STEPS * US_PER_STEP);
        end else if (req_code_q > cur_code_q) begin
            wait_val = diff_ext * WAIT_W'(US_PER_STEP);
        end else begin
            wait_val = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (skip || wait_val == '0) state_d = ST_FINISH;
                else                        state_d = ST_SETTLE;
            end
            ST_SETTLE: if (timer_fire) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_FINISH: done      = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_code_q  <= '0;
            cur_code_q  <= '0;
            init_done_q <= 1'b0;
            word_q      <= '0;
            err_q       <= 1'b0;
        end else begin
            if (accept) begin
                req_code_q <= conv_code;
                if (conv_clamped) err_q <= 1'b1;
            end
            if (timer_load) begin
                word_q      <= packed_word;
                cur_code_q  <= req_code_q;
                init_done_q <= 1'b1;
            end
        end
    end

    assign ctrl_word = word_q;
    assign clamp_err = err_q;

    // Assertions
    assert_cpu_periph_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[RAIL_CPU*CODE_W +: CODE_W] == ctrl_word[RAIL_PERIPH*CODE_W +: CODE_W]);

    assert_soc_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |-> ctrl_word[RAIL_SOC*CODE_W +: CODE_W] >= CODE_W'(SOC_FLOOR));

    assert_cpu_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_q |-> ctrl_word[RAIL_CPU*CODE_W +: CODE_W] >= CODE_W'(CPU_MIN_CODE));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_err |=> clamp_err);

    assert_word_stable_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |=> $stable(ctrl_word));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/vrail_seq_bench.sv
module vrail_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_mv = '0;
    logic [14:0] ctrl_word;
    logic        done;
    logic        clamp_err;

    int n_tests = 0;
    int n_fail  = 0;

    int  m_cur  = 0;
    bit  m_init = 0;
    bit  m_err  = 0;

    always #4 clk = ~clk;

    vrail_seq u_vrail_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_mv    (req_mv),
        .ctrl_word (ctrl_word),
        .done      (done),
        .clamp_err (clamp_err)
    );

    function automatic int exp_code(int mv);
        int c;
        if (mv < 950) return 10;
        c = (mv - 700) / 25;
        if (c > 31) return 31;
        return c;
    endfunction

    function automatic bit exp_clamp(int mv);
        return (mv < 950) || (((mv - 700) / 25) > 31);
    endfunction

    function automatic logic [14:0] exp_word(int c);
        int s;
        s = (c < 18) ? 18 : c;
        return {5'(s), 5'(c), 5'(c)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(int mv);
        int c, ticks, exp_ticks;
        logic [14:0] old_word, exp_w;
        bit write;
        c = exp_code(mv);
        write = !m_init || (c != m_cur);
        if (!m_init)       exp_ticks = 168;
        else if (c > m_cur) exp_ticks = (c - m_cur) * 6;
        else               exp_ticks = 0;
        if (exp_clamp(mv)) m_err = 1;

        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready idle", int'(req_ready), 1);
        old_word  = ctrl_word;
        req_mv    = 12'(mv);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 ready busy", int'(req_ready), 0);
        @(negedge clk);
        ticks = 0;
        while (!done && ticks < 400) begin
            check(req_ready == 1'b0, "R10 ready settle", int'(req_ready), 0);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            ticks++;
        end
        check(done == 1'b1, "R10 done seen", int'(done), 1);
        exp_w = write ? exp_word(c) : old_word;
        if (!m_init)
            check(ticks == exp_ticks, "R9 first settle", ticks, exp_ticks);
        else if (!write)
            check(ticks == 0 && ctrl_word == old_word, "R8 equal no write", ticks, 0);
        else if (exp_ticks > 0)
            check(ticks == exp_ticks, "R6 up settle", ticks, exp_ticks);
        else
            check(ticks == 0, "R7 down no settle", ticks, 0);
        check(ctrl_word[9:0] == exp_w[9:0], "R2 cpu/periph codes", int'(ctrl_word[9:0]), int'(exp_w[9:0]));
        check(ctrl_word[14:10] == exp_w[14:10], "R3 soc code", int'(ctrl_word[14:10]), int'(exp_w[14:10]));
        if (exp_clamp(mv))
            check(clamp_err == 1'b1, "R4 clamp flag", int'(clamp_err), 1);
        else
            check(clamp_err == m_err, "R5 sticky flag", int'(clamp_err), int'(m_err));
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R10 release", int'({done, req_ready}), 1);
        if (write) m_cur = c;
        m_init = 1;
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(clamp_err == 1'b0, "R1 reset err", int'(clamp_err), 0);
        check(ctrl_word == 15'd0, "R1 reset word", int'(ctrl_word), 0);

        do_req(1000);   // R9 first update, soc floor
        do_req(1000);   // R8 equal
        do_req(1010);   // R8 same code between grid points
        do_req(1150);   // R6 upward
        do_req(950);    // R7 downward
        do_req(1475);   // R6 to ceiling
        do_req(1100);   // R7
        do_req(949);    // R4 low clamp
        do_req(1200);   // R5 sticky after in-range
        do_req(1600);   // R4 high clamp
        for (int i = 0; i < 30; i++) begin
            do_req(600 + int'($urandom_range(0, 1000)));
        end

        rst_n = 1'b0;
        m_init = 0; m_cur = 0; m_err = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(clamp_err == 1'b0, "R5 cleared by reset", int'(clamp_err), 0);
        check(ctrl_word == 15'd0, "R1 word after reset", int'(ctrl_word), 0);
        do_req(700);    // R9 first after reset, clamped low
        do_req(1300);   // R6

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule